// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block sits on a two-wire serial bus as a target device and gives an external bus master byte-wide read and write access to a local bank of registers. A fast system clock samples the bus clock and data lines. The block detects start and stop conditions and decodes a 7-bit device address. A strap pin moves that address between two neighbouring values. The block pulls the data line low to acknowledge.

Every write transfer carries a subaddress byte first. That byte loads a register pointer. Each data byte that follows goes to the register the pointer names, and the pointer then steps forward. A read transfer returns bytes from the pointer onward, so one transfer can cover a run of consecutive registers. The usual read sequence is a subaddress write followed by a repeated start in read mode.

Each stored byte also appears on a strobe output together with its address. That output is valid-only and has no ready input. The serial bus cannot be stalled, so a consumer must take every strobe in the cycle it appears. The data line is open-drain: the block only ever requests a low level.

Top module: `i2c_regbank_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start, and a rising SDA while SCL is high is a stop. A start at any point, including part-way through a byte, begins a new address byte. After a stop the block releases SDA and ignores bits until the next start. The pointer survives both conditions.
- R2: The 8-bit address byte is matched on its upper seven bits. With addr_sel=0 the block answers 0x40 (write) and 0x41 (read). With addr_sel=1 it answers 0x42 and 0x43. Bit 0 is the direction, where 1 means read. On a mismatch the block leaves SDA released for the whole transfer and stores nothing.
- R3: In a write transfer the block acknowledges the address byte, the subaddress byte and every data byte by driving SDA low on the ninth clock. It stores each data byte in the register the pointer names.
- R4: Each stored byte produces a one-cycle pulse on wr_stb. The register index appears on wr_addr and the byte on wr_data in the same cycle. Non-matching transfers and reads produce no pulses.
- R5: The pointer advances by one after every data byte, written or read. It wraps from 0xFF to 0x00.
- R6: A read byte is shifted out MSB first, one bit per SCL period. SDA is released on the ninth clock. When the master acknowledges, the block continues with the next register.
- R7: When the master does not acknowledge a read byte, the block stops driving SDA. It stays released through any further clocks until the next start.
- R8: A read begins at the pointer set by the most recent subaddress, advanced by every data byte transferred since then.
- R9: After reset SDA is released, wr_stb is low and every register reads 0x00.
- R10: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_sel | input | 1 | Strap: picks 0x40/0x41 (0) or 0x42/0x43 (1) |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_stb | output | 1 | One-cycle pulse per stored byte |
| wr_addr | output | REG_AW | Register index of the stored byte |
| wr_data | output | 8 | Stored byte value |

## Verification
SCL and SDA reach the decision logic two clocks after they change on the wire, and edge detection adds no register. The SDA drive and the write strobe are registered, so both change on the third clock after the SCL falling edge that ends a bit. The bench holds each SCL phase for 16 clocks. It changes SDA 8 clocks into the low phase and samples the wired bus 8 clocks into the high phase, well clear of that 3-clock latency. Strobes are logged on every falling clock edge and compared with the expected register writes after each stop.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_SUB,
    ST_ACK_SUB,
    ST_WDATA,
    ST_ACK_WDATA,
    ST_RDATA,
    ST_RACK
  } rb_state_e;
endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  // Conditions are valid only while SCL stays high across both samples.
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_rb_fsm.sv
module i2c_rb_fsm
  import i2c_rb_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    dev_addr,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [PW-1:0] ptr,
  output logic          wr_stb,
  output logic [PW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);
  rb_state_e st;
  logic [2:0] bitcnt;
  logic       got8;
  logic [7:0] sr;
  logic [6:0] tx;
  logic       rnw;
  logic       mack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      got8    <= 1'b0;
      sr      <= '0;
      tx      <= '0;
      rnw     <= 1'b0;
      mack    <= 1'b0;
      ptr     <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        st     <= ST_ADDR;
        bitcnt <= '0;
        got8   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        bitcnt <= '0;
        got8   <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        if (scl_rise) begin
          case (st)
            ST_ADDR, ST_SUB, ST_WDATA: begin
              sr     <= {sr[6:0], sda_lvl};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) got8 <= 1'b1;
            end
            ST_RDATA: begin
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) got8 <= 1'b1;
            end
            ST_RACK: mack <= ~sda_lvl;
            default: ;
          endcase
        end
        if (scl_fall) begin
          case (st)
            ST_ADDR: if (got8) begin
              got8 <= 1'b0;
              if (sr[7:1] == dev_addr) begin
                rnw    <= sr[0];
                sda_oe <= 1'b1;
                st     <= ST_ACK_ADDR;
              end else begin
                st <= ST_IDLE;
              end
            end
            ST_SUB: if (got8) begin
              got8   <= 1'b0;
              ptr    <= sr[PW-1:0];
              sda_oe <= 1'b1;
              st     <= ST_ACK_SUB;
            end
            ST_WDATA: if (got8) begin
              got8    <= 1'b0;
              wr_stb  <= 1'b1;
              wr_addr <= ptr;
              wr_data <= sr;
              ptr     <= ptr + PW'(1);
              sda_oe  <= 1'b1;
              st      <= ST_ACK_WDATA;
            end
            ST_ACK_ADDR: begin
              if (rnw) begin
                tx     <= rd_data[6:0];
                sda_oe <= ~rd_data[7];
                st     <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_SUB;
              end
            end
            ST_ACK_SUB, ST_ACK_WDATA: begin
              sda_oe <= 1'b0;
              st     <= ST_WDATA;
            end
            ST_RDATA: begin
              if (got8) begin
                got8   <= 1'b0;
                sda_oe <= 1'b0;
                ptr    <= ptr + PW'(1);
                st     <= ST_RACK;
              end else begin
                sda_oe <= ~tx[6];
                tx     <= {tx[5:0], 1'b0};
              end
            end
            ST_RACK: begin
              if (mack) begin
                tx     <= rd_data[6:0];
                sda_oe <= ~rd_data[7];
                st     <= ST_RDATA;
              end else begin
                st <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter int         REG_AW      = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h20,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [REG_AW-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [REG_AW-1:0] ptr;
  logic [7:0] rd_data;
  logic [6:0] dev_addr;

  assign dev_addr = {DEV_ADDR[6:1], DEV_ADDR[0] ^ addr_sel};

  i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rb_fsm #(.PW(REG_AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .ptr(ptr), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  i2c_rb_regfile #(.AW(REG_AW), .DW(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_stb), .waddr(wr_addr),
    .wdata(wr_data), .raddr(ptr), .rdata(rd_data)
  );
endmodule

// File: rtl/i2c_rb_checker.sv
module i2c_rb_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_in,
  input logic          sda_oe,
  input logic          wr_stb,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] ptr,
  input logic          stop_det
);
  // R1: a stop always leaves the data line released
  a_r1_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R3: a stored byte is acknowledged in the same cycle it is strobed
  a_r3_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> sda_oe);

  // R4: the strobe lasts exactly one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R5: pointer has moved one past the stored index, wrapping
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ptr == wr_addr + AW'(1));

  // R10: drive changes only while the bus clock is low
  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in);
endmodule

bind i2c_regbank_slave i2c_rb_checker #(.AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .ptr(ptr), .stop_det(stop_det)
);

// File: tb/test_i2c_regbank_slave.sv
module test_i2c_regbank_slave;
  localparam int HP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_stb;
  logic [7:0] wr_addr, wr_data;
  wire sda_bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_regbank_slave i_i2c_regbank_slave (
    .clk(clk), .rst_n(rst_n), .addr_sel(sel), .scl_in(scl), .sda_in(sda_bus),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int vecs = 0;
  int errs = 0;
  logic [7:0] model [256];
  logic [7:0] mptr = 8'h00;
  logic [7:0] wbuf [16];
  logic [7:0] log_a [4096];
  logic [7:0] log_d [4096];
  int log_n = 0;
  int r10_bad = 0;
  logic scl_q = 1'b1;
  logic oe_d = 1'b0;

  always @(negedge clk) if (rst_n && wr_stb && log_n < 4096) begin
    log_a[log_n] = wr_addr;
    log_d[log_n] = wr_data;
    log_n++;
  end

  always @(posedge clk) scl_q <= scl;
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_d) && scl_q) r10_bad++;
    oe_d = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dev_byte(input logic s, input logic rd);
    return 8'h40 | {6'b0, s, 1'b0} | {7'b0, rd};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(HP/2);
    scl = 1'b1;   tick(HP);
    sda_m = 1'b0; tick(HP);
    scl = 1'b0;   tick(HP/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HP/2);
    scl = 1'b1;   tick(HP);
    sda_m = 1'b1; tick(HP);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;  tick(HP/2);
    scl = 1'b1; tick(HP);
    scl = 1'b0; tick(HP/2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(HP/2);
    scl = 1'b1;   tick(HP/2);
    ack = ~sda_bus; tick(HP/2);
    scl = 1'b0;   tick(HP/2);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HP/2);
      scl = 1'b1; tick(HP/2);
      b[i] = sda_bus; tick(HP/2);
      scl = 1'b0;
    end
    tick(HP/2);
    sda_m = give_ack ? 1'b0 : 1'b1; tick(HP/2);
    scl = 1'b1; tick(HP);
    scl = 1'b0; tick(HP/2);
    sda_m = 1'b1;
  endtask

  // Write transfer; wbuf holds the data bytes
  task automatic do_write(input logic [7:0] dev, input logic [7:0] sub,
                          input int n, input logic exp_ack);
    logic ack;
    int base;
    logic [7:0] p;
    base = log_n;
    p = sub;
    bus_start();
    send_byte(dev, ack); chk("R2 address ack", ack, exp_ack);
    send_byte(sub, ack); chk("R3 subaddress ack", ack, exp_ack);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack); chk("R3 data ack", ack, exp_ack);
    end
    bus_stop();
    tick(4);
    chk("R4 strobe count", log_n - base, exp_ack ? n : 0);
    if (exp_ack) begin
      for (int i = 0; i < n; i++) begin
        chk("R4 strobe addr", log_a[base+i], p);
        chk("R4 strobe data", log_d[base+i], wbuf[i]);
        model[p] = wbuf[i];
        p = p + 8'd1;
      end
      mptr = p;
    end
  endtask

  task automatic do_read(input logic setsub, input logic [7:0] sub,
                         input int n, input string req);
    logic ack;
    logic [7:0] b;
    if (setsub) begin
      bus_start();
      send_byte(dev_byte(sel, 1'b0), ack); chk("R2 address ack", ack, 1'b1);
      send_byte(sub, ack); chk("R3 subaddress ack", ack, 1'b1);
      mptr = sub;
    end
    bus_start();
    send_byte(dev_byte(sel, 1'b1), ack); chk("R2 read address ack", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(req, b, model[mptr]);
      mptr = mptr + 8'd1;
    end
    chk("R7 released after nack", sda_oe, 1'b0);
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    tick(5);
    chk("R9 sda released in reset", sda_oe, 1'b0);
    rst_n = 1'b1;
    tick(5);
    chk("R9 sda released", sda_oe, 1'b0);
    chk("R9 strobe low", wr_stb, 1'b0);

    do_read(1'b1, 8'h05, 2, "R9 reset register value");

    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
    do_write(8'h44, 8'h10, 2, 1'b0);
    do_read(1'b1, 8'h10, 1, "R2 mismatch stored nothing");

    for (int i = 0; i < 5; i++) wbuf[i] = 8'h11 * (i + 1) ^ 8'h80;
    do_write(dev_byte(1'b0, 1'b0), 8'h10, 5, 1'b1);
    do_read(1'b1, 8'h10, 3, "R6 burst read");
    do_read(1'b0, 8'h00, 2, "R8 read continues at pointer");

    wbuf[0] = 8'hDE; wbuf[1] = 8'hAD; wbuf[2] = 8'hBE;
    do_write(dev_byte(1'b0, 1'b0), 8'hFE, 3, 1'b1);
    chk("R5 wrap pointer", mptr, 8'h01);
    do_read(1'b1, 8'hFE, 3, "R5 wrap read");

    sel = 1'b1;
    wbuf[0] = 8'h5A;
    do_write(8'h40, 8'h30, 1, 1'b0);
    do_write(8'h42, 8'h30, 1, 1'b1);
    do_read(1'b1, 8'h30, 1, "R2 strap pair read");

    // R7: after the nack, further clocks read back all ones
    bus_start();
    send_byte(8'h43, ack); chk("R2 read address ack", ack, 1'b1);
    recv_byte(1'b0, b); chk("R6 single byte", b, model[mptr]);
    mptr = mptr + 8'd1;
    recv_byte(1'b0, b); chk("R7 silent after nack", b, 8'hFF);
    bus_stop();

    // R1: stop after subaddress, then read without a new subaddress
    bus_start();
    send_byte(8'h42, ack); chk("R1 address ack", ack, 1'b1);
    send_byte(8'h30, ack); chk("R1 subaddress ack", ack, 1'b1);
    mptr = 8'h30;
    bus_stop();
    tick(4);
    chk("R1 released after stop", sda_oe, 1'b0);
    do_read(1'b0, 8'h00, 1, "R1 pointer kept across stop");

    // R1: start part-way through a byte restarts address decoding
    bus_start();
    send_byte(8'h42, ack); chk("R1 address ack", ack, 1'b1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    wbuf[0] = 8'h77; wbuf[1] = 8'h88;
    do_write(8'h42, 8'h50, 2, 1'b1);
    do_read(1'b1, 8'h50, 2, "R1 repeated start write");

    for (int it = 0; it < 16; it++) begin
      logic [7:0] sub;
      int n;
      sub = 8'($urandom % 256);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(dev_byte(sel, 1'b0), sub, n, 1'b1);
      do_read(1'b1, sub, n, "R3 random readback");
    end

    chk("R10 drive changed with SCL high", r10_bad, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule